// File: doc/BRIEF.md
# Pseudo-Random Noise Voice

This block is one voice of a retro-style sound generator. A frequency timer steps a 15-bit linear feedback shift register, which can be narrowed to a 7-bit sequence. Each time the timer expires, the inverted low bit of the register gates the current volume onto a 4-bit sample output. A length counter can silence the voice after a programmed number of length strobes. A simple volume envelope ramps the level up or down once per programmed number of envelope strobes. Both strobes come from a frame sequencer outside the block.

Software programs the voice through a byte-wide register port and then starts it with a trigger write. The port is decoded by a 2-bit address:

| Address | Register |
|---|---|
| 0 | length |
| 1 | envelope |
| 2 | frequency |
| 3 | control |

The block outputs the sample and a flag that is high while the voice is sounding. Mixing, panning and conversion to analogue are done downstream.

Top module: `noise_channel`

## Requirements
- R1: The timer reload period is 8 << S when the divisor code D (frequency bits 2:0) is 0, and (16 × D) << S otherwise, where S is frequency bits 7:4.
- R2: After a trigger, the first timer interval is half the period plus 8 clocks. If the voice was already enabled when triggered, 4 more clocks are added.
- R3: On each timer expiry, the feedback bit is register bit 0 XOR bit 1. The register then shifts right by one and the feedback enters bit 14. Starting from all ones, bit 0 first reads 0 after 15 expiries.
- R4: When frequency bit 3 is set, the feedback is also written into bit 6 after the shift. Starting from all ones, bit 0 then first reads 0 after 7 expiries.
- R5: With a shift code of 14 or 15 the register receives no steps, so the sample holds its value.
- R6: On each expiry while enabled, the sample becomes the volume when the new bit 0 is 0, and 0 otherwise. The sample is 0 whenever the voice is disabled.
- R7: Writing the length register (address 0) loads the length count with 64 minus data bits 5:0.
- R8: A length strobe decrements the count only while length is enabled and the count is nonzero. A count that reaches zero this way disables the voice.
- R9: A control write (address 3) with bit 7 set is a trigger. It loads the volume from envelope bits 7:4, reloads the envelope countdown, and sets the shift register to all ones. It sets the length count to 64 if it was 0. It enables the voice only if envelope bits 7:4 are nonzero or envelope bit 3 (increase) is set.
- R10: Control data bit 6 sets length-enable. Reading address 3 returns only that flag, in bit 6.
- R11: Reading address 1 returns the stored envelope byte, laid out as volume 7:4, increase 3, period 2:0. Reading address 2 returns the stored frequency byte. Reading address 0 returns 0.
- R12: With a nonzero envelope period P, every P-th envelope strobe moves the volume one step toward 15 (increase) or toward 0, stopping at the limit. A period of 0 leaves the volume unchanged.
- R13: After reset the voice is disabled, the sample is 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 length, 1 envelope, 2 frequency, 3 control |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for reg_addr (combinational) |
| len_tick | input | 1 | Length-clock strobe from the frame sequencer |
| env_tick | input | 1 | Envelope-clock strobe from the frame sequencer |
| sample | output | 4 | Current output sample |
| active | output | 1 | Voice enabled flag |

## Verification
The bench builds the block with its default parameters: a 15-bit register with its short tap at bit 6, a 6-bit length field, and 4-bit shift and 3-bit divisor codes. Random frequency writes mostly use shift codes 0 to 3, so the register steps many times within a short run. A few writes use codes 14 and 15 to reach the frozen state. Directed cases measure the exact first-output cycle for the 7-bit and 15-bit widths, for a nonzero divisor and for a restart of a running voice. Other directed cases cover the full 64-step length reload after a trigger and the trigger that leaves the voice silent.

// File: rtl/noise_pkg.sv
package noise_pkg;

  typedef enum logic [1:0] {
    REG_LEN  = 2'd0,
    REG_ENV  = 2'd1,
    REG_FREQ = 2'd2,
    REG_CTRL = 2'd3
  } reg_sel_e;

  localparam int CTRL_TRIG_BIT = 7;
  localparam int CTRL_LEN_BIT  = 6;
  localparam int TRIG_BIAS     = 8;
  localparam int RESTART_EXTRA = 4;

endpackage

// File: rtl/noise_rst_sync.sv
module noise_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/noise_timer.sv
module noise_timer #(
  parameter int DIV_W   = 3,
  parameter int SHIFT_W = 4,
  parameter int TIMER_W = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               trig,
  input  logic               restart,
  input  logic [DIV_W-1:0]   div,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  import noise_pkg::*;

  logic [TIMER_W-1:0] base, period, first, cnt_q, cnt_d;

  always_comb begin
    base   = (div == '0) ? TIMER_W'(8) : (TIMER_W'(div) << 4);
    period = base << shift;
    first  = (period >> 1) + TIMER_W'(TRIG_BIAS)
           + (restart ? TIMER_W'(RESTART_EXTRA) : '0);
  end

  always_comb begin
    cnt_d = cnt_q;
    tick  = 1'b0;
    if (trig) begin
      cnt_d = first;
    end else if (run) begin
      if (cnt_q <= TIMER_W'(1)) begin
        cnt_d = period;
        tick  = 1'b1;
      end else begin
        cnt_d = cnt_q - TIMER_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr #(
  parameter int WIDTH     = 15,
  parameter int SHORT_TAP = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             step,
  input  logic             short_mode,
  output logic [WIDTH-1:0] q,
  output logic             next_lsb
);

  logic [WIDTH-1:0] shifted, q_d;
  logic             fb;

  always_comb begin
    fb      = q[0] ^ q[1];
    shifted = {fb, q[WIDTH-1:1]};
    if (short_mode) shifted[SHORT_TAP] = fb;
    next_lsb = shifted[0];
    if (trig)      q_d = '1;
    else if (step) q_d = shifted;
    else           q_d = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '1;
    else        q <= q_d;
  end

endmodule

// File: rtl/noise_length.sv
module noise_length #(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             trig,
  input  logic             tick,
  input  logic             len_en,
  output logic [LEN_W:0]   cnt,
  output logic             expire
);

  localparam int FULL = 1 << LEN_W;

  logic [LEN_W:0] cnt_d;

  always_comb begin
    cnt_d  = cnt;
    expire = 1'b0;
    if (load) begin
      cnt_d = (LEN_W+1)'(FULL) - {1'b0, load_val};
    end else if (trig) begin
      if (cnt == '0) cnt_d = (LEN_W+1)'(FULL);
    end else if (tick && len_en && (cnt != '0)) begin
      cnt_d  = cnt - (LEN_W+1)'(1);
      expire = (cnt == (LEN_W+1)'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

endmodule

// File: rtl/noise_env.sv
module noise_env #(
  parameter int VOL_W  = 4,
  parameter int EPER_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic              tick,
  input  logic [VOL_W-1:0]  init_vol,
  input  logic              dir_up,
  input  logic [EPER_W-1:0] per,
  output logic [VOL_W-1:0]  vol
);

  logic [VOL_W-1:0]  vol_d;
  logic [EPER_W-1:0] ecnt_q, ecnt_d;

  always_comb begin
    vol_d  = vol;
    ecnt_d = ecnt_q;
    if (trig) begin
      vol_d  = init_vol;
      ecnt_d = per;
    end else if (tick && (per != '0)) begin
      if (ecnt_q <= EPER_W'(1)) begin
        ecnt_d = per;
        if (dir_up && (vol != {VOL_W{1'b1}}))  vol_d = vol + VOL_W'(1);
        else if (!dir_up && (vol != '0))       vol_d = vol - VOL_W'(1);
      end else begin
        ecnt_d = ecnt_q - EPER_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vol    <= '0;
      ecnt_q <= '0;
    end else begin
      vol    <= vol_d;
      ecnt_q <= ecnt_d;
    end
  end

endmodule

// File: rtl/noise_channel.sv
module noise_channel #(
  parameter int LFSR_W      = 15,
  parameter int SHORT_TAP   = 6,
  parameter int LEN_W       = 6,
  parameter int VOL_W       = 4,
  parameter int EPER_W      = 3,
  parameter int DIV_W       = 3,
  parameter int SHIFT_W     = 4,
  parameter int STOP_SHIFT  = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  input  logic             len_tick,
  input  logic             env_tick,
  output logic [VOL_W-1:0] sample,
  output logic             active
);
  import noise_pkg::*;

  localparam int TIMER_W   = DIV_W + 4 + (1 << SHIFT_W) - 1;
  localparam int ENV_DIR_B = EPER_W;
  localparam int FRQ_WID_B = DIV_W;

  logic srst_n;

  noise_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(srst_n)
  );

  // register state
  logic [7:0]       env_q, env_d, freq_q, freq_d;
  logic             len_en_q, len_en_d, en_q, en_d;
  logic [VOL_W-1:0] sample_q, sample_d;

  logic wr_len, wr_env, wr_freq, wr_ctrl, trig;
  logic [VOL_W-1:0]   env_init;
  logic               env_dir;
  logic [EPER_W-1:0]  env_per;
  logic [SHIFT_W-1:0] freq_shift;
  logic               freq_short;
  logic [DIV_W-1:0]   freq_div;
  logic               run, tick, len_expire, lfsr_next_lsb;
  logic [LFSR_W-1:0]  lfsr_q;
  logic [LEN_W:0]     len_cnt;
  logic [VOL_W-1:0]   vol;

  always_comb begin
    wr_len  = wr_en && (reg_addr == REG_LEN);
    wr_env  = wr_en && (reg_addr == REG_ENV);
    wr_freq = wr_en && (reg_addr == REG_FREQ);
    wr_ctrl = wr_en && (reg_addr == REG_CTRL);
    trig    = wr_ctrl && wr_data[CTRL_TRIG_BIT];
    env_init   = env_q[7 -: VOL_W];
    env_dir    = env_q[ENV_DIR_B];
    env_per    = env_q[EPER_W-1:0];
    freq_shift = freq_q[7 -: SHIFT_W];
    freq_short = freq_q[FRQ_WID_B];
    freq_div   = freq_q[DIV_W-1:0];
    run        = en_q && (freq_shift < SHIFT_W'(STOP_SHIFT));
  end

  noise_timer #(.DIV_W(DIV_W), .SHIFT_W(SHIFT_W), .TIMER_W(TIMER_W)) u_timer (
    .clk(clk), .rst_n(srst_n), .run(run), .trig(trig), .restart(en_q),
    .div(freq_div), .shift(freq_shift), .tick(tick)
  );

  noise_lfsr #(.WIDTH(LFSR_W), .SHORT_TAP(SHORT_TAP)) u_lfsr (
    .clk(clk), .rst_n(srst_n), .trig(trig), .step(tick),
    .short_mode(freq_short), .q(lfsr_q), .next_lsb(lfsr_next_lsb)
  );

  noise_length #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(srst_n), .load(wr_len), .load_val(wr_data[LEN_W-1:0]),
    .trig(trig), .tick(len_tick), .len_en(len_en_q),
    .cnt(len_cnt), .expire(len_expire)
  );

  noise_env #(.VOL_W(VOL_W), .EPER_W(EPER_W)) u_env (
    .clk(clk), .rst_n(srst_n), .trig(trig), .tick(env_tick),
    .init_vol(env_init), .dir_up(env_dir), .per(env_per), .vol(vol)
  );

  always_comb begin
    env_d    = wr_env  ? wr_data : env_q;
    freq_d   = wr_freq ? wr_data : freq_q;
    len_en_d = wr_ctrl ? wr_data[CTRL_LEN_BIT] : len_en_q;

    en_d = en_q;
    if (trig)            en_d = (env_init != '0) || env_dir;
    else if (len_expire) en_d = 1'b0;

    sample_d = sample_q;
    if (!en_d)                sample_d = '0;
    else if (trig && en_q)    sample_d = lfsr_q[0] ? '0 : env_init;
    else if (!trig && tick)   sample_d = lfsr_next_lsb ? '0 : vol;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      env_q    <= '0;
      freq_q   <= '0;
      len_en_q <= 1'b0;
      en_q     <= 1'b0;
      sample_q <= '0;
    end else begin
      env_q    <= env_d;
      freq_q   <= freq_d;
      len_en_q <= len_en_d;
      en_q     <= en_d;
      sample_q <= sample_d;
    end
  end

  always_comb begin
    unique case (reg_sel_e'(reg_addr))
      REG_ENV:  rd_data = env_q;
      REG_FREQ: rd_data = freq_q;
      REG_CTRL: rd_data = len_en_q ? (8'h01 << CTRL_LEN_BIT) : 8'h00;
      default:  rd_data = 8'h00;
    endcase
  end

  assign sample = sample_q;
  assign active = en_q;

endmodule

// File: rtl/noise_channel_chk.sv
module noise_channel_chk #(
  parameter int LFSR_W     = 15,
  parameter int LEN_W      = 6,
  parameter int VOL_W      = 4,
  parameter int SHIFT_W    = 4,
  parameter int EPER_W     = 3,
  parameter int STOP_SHIFT = 14
) (
  input logic               clk,
  input logic               srst_n,
  input logic               trig,
  input logic               wr_en,
  input logic [1:0]         reg_addr,
  input logic [7:0]         wr_data,
  input logic               len_tick,
  input logic               len_en,
  input logic [LEN_W:0]     len_cnt,
  input logic               active,
  input logic [VOL_W-1:0]   sample,
  input logic [LFSR_W-1:0]  lfsr,
  input logic [SHIFT_W-1:0] shift,
  input logic               env_tick,
  input logic [EPER_W-1:0]  env_per,
  input logic [VOL_W-1:0]   vol
);
  localparam int FULL = 1 << LEN_W;

  a_r6_silent_when_off: assert property (@(posedge clk) disable iff (!srst_n)
    !active |-> (sample == '0));

  a_r9_seed_all_ones: assert property (@(posedge clk) disable iff (!srst_n)
    trig |=> (lfsr == '1));

  a_r5_frozen_shift: assert property (@(posedge clk) disable iff (!srst_n)
    (shift >= SHIFT_W'(STOP_SHIFT) && !trig) |=> $stable(lfsr));

  a_r7_length_load: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_en && reg_addr == 2'd0) |=>
      (int'(len_cnt) == FULL - int'($past(wr_data[LEN_W-1:0]))));

  a_r8_expire_disables: assert property (@(posedge clk) disable iff (!srst_n)
    (active && len_tick && len_en && len_cnt == (LEN_W+1)'(1) && !trig) |=> !active);

  a_r10_len_enable_bit: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_en && reg_addr == 2'd3) |=> (len_en == $past(wr_data[6])));

  a_r12_zero_period_holds: assert property (@(posedge clk) disable iff (!srst_n)
    (env_tick && env_per == '0 && !trig) |=> $stable(vol));

endmodule

bind noise_channel noise_channel_chk #(
  .LFSR_W(LFSR_W), .LEN_W(LEN_W), .VOL_W(VOL_W), .SHIFT_W(SHIFT_W),
  .EPER_W(EPER_W), .STOP_SHIFT(STOP_SHIFT)
) u_chk (
  .clk(clk), .srst_n(srst_n), .trig(trig), .wr_en(wr_en), .reg_addr(reg_addr),
  .wr_data(wr_data), .len_tick(len_tick), .len_en(len_en_q), .len_cnt(len_cnt),
  .active(en_q), .sample(sample_q), .lfsr(lfsr_q), .shift(freq_shift),
  .env_tick(env_tick), .env_per(env_per), .vol(vol)
);

// File: tb/noise_channel_tb.sv
module noise_channel_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, len_tick, env_tick;
  logic [1:0] reg_addr;
  logic [7:0] wr_data, rd_data;
  logic [3:0] sample;
  logic       active;

  int n_checks = 0;
  int n_errs   = 0;

  always #10 clk = ~clk;

  noise_channel u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .len_tick(len_tick),
    .env_tick(env_tick), .sample(sample), .active(active)
  );

  // reference state, built from the requirements
  logic [7:0]  m_env = 8'h00, m_freq = 8'h00;
  logic [14:0] m_lfsr = 15'h7fff;
  int m_len = 0, m_vol = 0, m_ecnt = 0, m_tmr = 0, m_sample = 0;
  bit m_len_en = 0, m_en = 0;

  function automatic int period_of(logic [7:0] f);
    int dv = int'(f[2:0]);
    int base = (dv == 0) ? 8 : 16 * dv;
    return base << f[7:4];
  endfunction

  function automatic int exp_rd(logic [1:0] a);
    case (a)
      2'd1:    return int'(m_env);
      2'd2:    return int'(m_freq);
      2'd3:    return m_len_en ? 8'h40 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic model_step(bit w, logic [1:0] a, logic [7:0] d, bit lt, bit et);
    bit trig = w && a == 2'd3 && d[7];
    bit old_en = m_en;
    logic [14:0] old_l = m_lfsr;
    int vol_old = m_vol;
    bit run = m_en && (m_freq[7:4] < 4'd14);
    bit tick = 0;
    bit expire = 0;
    int per = int'(m_env[2:0]);
    // R2 / R1 timer
    if (trig) m_tmr = period_of(m_freq) / 2 + 8 + (old_en ? 4 : 0);
    else if (run) begin
      if (m_tmr <= 1) begin tick = 1; m_tmr = period_of(m_freq); end
      else m_tmr--;
    end
    // R3 / R4 shift register
    if (trig) m_lfsr = 15'h7fff;
    else if (tick) begin
      logic fb = old_l[0] ^ old_l[1];
      m_lfsr = {fb, old_l[14:1]};
      if (m_freq[3]) m_lfsr[6] = fb;
    end
    // R7 / R8 length
    if (w && a == 2'd0) m_len = 64 - int'(d[5:0]);
    else if (trig) begin if (m_len == 0) m_len = 64; end
    else if (lt && m_len_en && m_len != 0) begin
      m_len--;
      if (m_len == 0) expire = 1;
    end
    // R12 envelope
    if (trig) begin m_vol = int'(m_env[7:4]); m_ecnt = per; end
    else if (et && per != 0) begin
      if (m_ecnt <= 1) begin
        m_ecnt = per;
        if (m_env[3] && m_vol < 15) m_vol++;
        else if (!m_env[3] && m_vol > 0) m_vol--;
      end else m_ecnt--;
    end
    // R9 enable
    if (trig) m_en = (m_env[7:4] != 0) || m_env[3];
    else if (expire) m_en = 0;
    // R6 sample
    if (!m_en) m_sample = 0;
    else if (trig) begin if (old_en) m_sample = old_l[0] ? 0 : int'(m_env[7:4]); end
    else if (tick) m_sample = m_lfsr[0] ? 0 : vol_old;
    // registers
    if (w) begin
      if (a == 2'd1) m_env = d;
      if (a == 2'd2) m_freq = d;
      if (a == 2'd3) m_len_en = d[6];
    end
  endtask

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit w, logic [1:0] a, logic [7:0] d, bit lt, bit et);
    wr_en = w; reg_addr = a; wr_data = d; len_tick = lt; env_tick = et;
    model_step(w, a, d, lt, et);
    @(negedge clk);
    chk("R6 R12 sample", int'(sample), m_sample);
    chk("R8 active", int'(active), int'(m_en));
    chk("R11 readback", int'(rd_data), exp_rd(a));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 2'd0, 8'h00, 0, 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int s_hold;
    int r;
    r = $urandom(32'd24681);
    rst_n = 1'b0; wr_en = 0; reg_addr = 0; wr_data = 0; len_tick = 0; env_tick = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R13 reset state
    chk("R13 sample", int'(sample), 0);
    chk("R13 active", int'(active), 0);
    for (int a = 0; a < 4; a++) begin
      step(0, 2'(a), 8'h00, 0, 0);
      chk("R13 read", int'(rd_data), 0);
    end

    // R4 R2: short width, period 8, idle voice -> first expiry after 12
    step(1, 2'd1, 8'hA0, 0, 0);
    step(1, 2'd2, 8'h08, 0, 0);
    step(1, 2'd3, 8'h80, 0, 0);
    chk("R9 enabled after trigger", int'(active), 1);
    idle(59); chk("R4 sample before 7th step", int'(sample), 0);
    idle(1);  chk("R4 sample at 7th step", int'(sample), 10);

    // R2 restart of running voice adds 4
    step(1, 2'd3, 8'h80, 0, 0);
    idle(63); chk("R2 restart before", int'(sample), 0);
    idle(1);  chk("R2 restart at", int'(sample), 10);

    // R3 wide mode: bit0 low after 15 expiries (running restart, first 16)
    step(1, 2'd2, 8'h00, 0, 0);
    step(1, 2'd3, 8'h80, 0, 0);
    idle(127); chk("R3 wide before", int'(sample), 0);
    idle(1);   chk("R3 wide at", int'(sample), 10);

    // R9 silent trigger, then R1 with divisor 1 and shift 1 (period 32)
    step(1, 2'd1, 8'h00, 0, 0);
    step(1, 2'd3, 8'h80, 0, 0);
    chk("R9 volume 0 decreasing stays off", int'(active), 0);
    step(1, 2'd1, 8'hA0, 0, 0);
    step(1, 2'd2, 8'h19, 0, 0);
    step(1, 2'd3, 8'h80, 0, 0);
    idle(215); chk("R1 before", int'(sample), 0);
    idle(1);   chk("R1 at", int'(sample), 10);

    // R5 shift code 14 freezes the register
    step(1, 2'd2, 8'hE8, 0, 0);
    step(1, 2'd3, 8'h80, 0, 0);
    s_hold = int'(sample);
    idle(300);
    chk("R5 frozen sample", int'(sample), s_hold);
    chk("R5 still active", int'(active), 1);

    // R7 R8 R10 length
    step(1, 2'd2, 8'h08, 0, 0);
    step(1, 2'd0, 8'h3D, 0, 0);
    step(1, 2'd3, 8'h40, 0, 0);
    step(0, 2'd3, 8'h00, 0, 0);
    chk("R10 control readback", int'(rd_data), 8'h40);
    step(0, 2'd0, 8'h00, 1, 0);
    step(0, 2'd0, 8'h00, 1, 0);
    chk("R7 count not yet zero", int'(active), 1);
    step(0, 2'd0, 8'h00, 1, 0);
    chk("R8 expiry disables", int'(active), 0);
    chk("R8 sample zero", int'(sample), 0);

    // R9 increase with volume 0 enables; zero count reloads to 64
    step(1, 2'd1, 8'h08, 0, 0);
    step(1, 2'd3, 8'hC0, 0, 0);
    chk("R9 increase enables", int'(active), 1);
    for (int i = 0; i < 63; i++) step(0, 2'd0, 8'h00, 1, 0);
    chk("R9 after 63 length strobes", int'(active), 1);
    step(0, 2'd0, 8'h00, 1, 0);
    chk("R9 after 64 length strobes", int'(active), 0);

    // R11 readback layout
    step(1, 2'd1, 8'h5B, 0, 0);
    step(1, 2'd2, 8'h3A, 0, 0);
    step(1, 2'd0, 8'h15, 0, 0);
    step(0, 2'd1, 8'h00, 0, 0); chk("R11 envelope", int'(rd_data), 8'h5B);
    step(0, 2'd2, 8'h00, 0, 0); chk("R11 frequency", int'(rd_data), 8'h3A);
    step(0, 2'd0, 8'h00, 0, 0); chk("R11 length reads 0", int'(rd_data), 0);

    // random phase against the reference
    for (int i = 0; i < 30000; i++) begin
      bit w = ($urandom % 16) == 0;
      logic [1:0] a = 2'($urandom % 4);
      logic [7:0] d = 8'($urandom % 256);
      if (a == 2'd2) begin
        logic [3:0] sh = (($urandom % 16) == 0) ? 4'(14 + $urandom % 2) : 4'($urandom % 4);
        d = {sh, d[3:0]};
      end
      step(w, a, d, ($urandom % 48) == 0, ($urandom % 24) == 0);
    end

    finish_run();
  end

endmodule